// File: doc/BRIEF.md
# Bus Ownership and CPU Reset Controller

This block lets an external agent take over the memory bus of a CPU that can hand its bus away through a request and acknowledge pair. A command port accepts four operations: hold the CPU in reset, request the bus, give the bus back, and restart the CPU. The block drives the CPU's reset line and its active-low bus request line. It watches the active-low acknowledge and turns on its own address and strobe drivers only after the CPU has let go of the bus.

The block keeps two facts apart: whether the CPU is held in reset or running, and whether the bus is owned. Together they form a two-bit state. Every wait for the acknowledge is bounded by a slow tick counter. A wait that runs out completes with an error flag. Each command finishes with a one-cycle done pulse, and the new state is valid in the same cycle.

Top module: `busown_ctrl`

## Requirements
- R1: After reset, `state` is 0, the CPU reset is asserted, `busreq_n` is 1, `bus_oe` is 0, and `done` and `busy` are 0.
- R2: `state` bit 0 means the bus is owned and bit 1 means the CPU is running. Codes: 0 held in reset, 1 held in reset with the bus owned, 2 running, 3 running with the bus owned. While `busy` is 0, `bus_oe` equals bit 0.
- R3: Command 1 (request) with bit 0 clear drives `busreq_n` low. Once `busack_n` is seen low, `bus_oe` goes to 1, bit 0 is set and `tmo_err` is 0.
- R4: If `busack_n` stays high through a request for TMO_TICKS ticks of TICK_DIV cycles each, `busreq_n` returns to 1, `state` stays unchanged and `tmo_err` is 1.
- R5: Command 2 (release) with bit 0 set first clears `bus_oe`, raises `busreq_n` on a later cycle, and then waits for `busack_n` high. Bit 0 is then cleared, and `tmo_err` is 1 only if the wait ran out.
- R6: Command 0 (reset) from any state asserts the CPU reset, drops the drivers, raises `busreq_n`, and ends in state 0.
- R7: Command 3 (restart) asserts the CPU reset for exactly RST_CYC cycles and then releases it. It sets bit 1, keeps bit 0, and leaves `bus_oe` and `busreq_n` unchanged.
- R8: With `rst_pol_high` at 1, an asserted CPU reset drives `cpu_reset` high. With it at 0, an asserted reset drives `cpu_reset` low.
- R9: A request while bit 0 is set, or a release while it is clear, completes with `done` on the next cycle and changes nothing.
- R10: A command presented while `busy` is 1 is ignored.
- R11: `done` lasts exactly one cycle, and `state` changes only in a cycle where `done` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| cmd_valid | input | 1 | Command strobe, taken when busy is 0 |
| cmd | input | 2 | 0 reset, 1 request, 2 release, 3 restart |
| rst_pol_high | input | 1 | 1: CPU reset is active high, 0: active low |
| busack_n | input | 1 | Bus acknowledge from the CPU, active low |
| cpu_reset | output | 1 | CPU reset pin level |
| busreq_n | output | 1 | Bus request to the CPU, active low |
| bus_oe | output | 1 | Enables the address drivers and the idle-high strobe drivers |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| state | output | 2 | Resulting state, valid with done |
| tmo_err | output | 1 | The last acknowledge wait ran out |

## Verification
The assertions assume that the acknowledge only falls after a request has been issued, and that it changes slowly compared with the two-stage synchronizer. They also assume that commands are held to single-cycle strobes. The bench models the CPU with three acknowledge behaviours: following the request line, never granting, and stuck granting. It changes the acknowledge and the command inputs only on the falling clock edge. This keeps every wait within those assumptions while still reaching both timeout paths.

// File: rtl/busown_ctrl.sv
module busown_ctrl #(
  parameter int TICK_DIV  = 10_000_000,
  parameter int TMO_TICKS = 2,
  parameter int RST_CYC   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd,
  input  logic       rst_pol_high,
  input  logic       busack_n,
  output logic       cpu_reset,
  output logic       busreq_n,
  output logic       bus_oe,
  output logic       busy,
  output logic       done,
  output logic [1:0] state,
  output logic       tmo_err
);

  localparam int CMAX = (TICK_DIV > RST_CYC) ? TICK_DIV : RST_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int TW   = $clog2(TMO_TICKS + 1);
  localparam logic [CW-1:0] DIV_LAST = CW'(TICK_DIV - 1);
  localparam logic [CW-1:0] PLS_LAST = CW'(RST_CYC - 1);
  localparam logic [TW-1:0] TMO_LIM  = TW'(TMO_TICKS);

  localparam logic [1:0] C_RESET = 2'd0, C_REQ = 2'd1, C_REL = 2'd2, C_RESTART = 2'd3;

  typedef enum logic [2:0] {P_IDLE, P_REQW, P_DROP, P_RELW, P_PULSE} phase_t;
  phase_t phase;

  logic [CW-1:0] cnt;
  logic [TW-1:0] ticks;
  logic [1:0]    ack_q;
  logic          ack_s, rst_on, tgt_run;
  wire           tmo = (ticks == TMO_LIM);

  assign ack_s     = ack_q[1];
  assign busy      = (phase != P_IDLE);
  assign cpu_reset = rst_pol_high ? rst_on : ~rst_on;

  always_ff @(posedge clk) begin
    if (!rst_n) ack_q <= 2'b11;
    else        ack_q <= {ack_q[0], busack_n};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= P_IDLE;
      state    <= 2'd0;
      rst_on   <= 1'b1;
      busreq_n <= 1'b1;
      bus_oe   <= 1'b0;
      done     <= 1'b0;
      tmo_err  <= 1'b0;
      cnt      <= '0;
      ticks    <= '0;
      tgt_run  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        P_IDLE: if (cmd_valid) begin
          unique case (cmd)
            C_RESET: begin
              bus_oe  <= 1'b0;
              rst_on  <= 1'b1;
              tgt_run <= 1'b0;
              phase   <= P_DROP;
            end
            C_REQ: if (state[0]) begin
              done <= 1'b1;
            end else begin
              busreq_n <= 1'b0;
              cnt      <= '0;
              ticks    <= '0;
              phase    <= P_REQW;
            end
            C_REL: if (!state[0]) begin
              done <= 1'b1;
            end else begin
              bus_oe  <= 1'b0;
              tgt_run <= state[1];
              phase   <= P_DROP;
            end
            C_RESTART: begin
              rst_on <= 1'b1;
              cnt    <= '0;
              phase  <= P_PULSE;
            end
          endcase
        end
        P_REQW: begin
          if (!ack_s) begin
            bus_oe   <= 1'b1;
            state[0] <= 1'b1;
            tmo_err  <= 1'b0;
            done     <= 1'b1;
            phase    <= P_IDLE;
          end else if (tmo) begin
            busreq_n <= 1'b1;
            tmo_err  <= 1'b1;
            done     <= 1'b1;
            phase    <= P_IDLE;
          end else if (cnt == DIV_LAST) begin
            cnt   <= '0;
            ticks <= ticks + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        P_DROP: begin
          busreq_n <= 1'b1;
          cnt      <= '0;
          ticks    <= '0;
          phase    <= P_RELW;
        end
        P_RELW: begin
          if (ack_s || tmo) begin
            state   <= {tgt_run, 1'b0};
            tmo_err <= !ack_s;
            done    <= 1'b1;
            phase   <= P_IDLE;
          end else if (cnt == DIV_LAST) begin
            cnt   <= '0;
            ticks <= ticks + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        P_PULSE: begin
          if (cnt == PLS_LAST) begin
            rst_on   <= 1'b0;
            state[1] <= 1'b1;
            tmo_err  <= 1'b0;
            done     <= 1'b1;
            phase    <= P_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= P_IDLE;
      endcase
    end
  end

  a_r3_oe_only_while_requesting: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !busreq_n);
  a_r3_oe_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(!ack_s));
  a_r5_drivers_off_before_unrequest: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busreq_n) |-> !$past(bus_oe));
  a_r2_oe_matches_owned: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_oe == state[0]));
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_state_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state) |-> done);

endmodule

// File: tb/test_busown_ctrl.sv
module test_busown_ctrl;
  localparam int DIV = 8, TMO = 2, RC = 4;

  logic clk = 0, rst_n = 0, cmd_valid = 0, pol = 1, busack_n = 1;
  logic [1:0] cmd = 0;
  logic cpu_reset, busreq_n, bus_oe, busy, done, tmo_err;
  logic [1:0] state;
  int ack_mode = 1;
  int errors = 0, checks = 0;
  int waited;
  bit timed_out = 0;

  busown_ctrl #(.TICK_DIV(DIV), .TMO_TICKS(TMO), .RST_CYC(RC)) i_busown_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .rst_pol_high(pol), .busack_n(busack_n), .cpu_reset(cpu_reset),
    .busreq_n(busreq_n), .bus_oe(bus_oe), .busy(busy), .done(done),
    .state(state), .tmo_err(tmo_err));

  always #5 clk = ~clk;

  always @(negedge clk)
    case (ack_mode)
      0: busack_n <= 1'b1;
      1: busack_n <= busreq_n;
      default: busack_n <= 1'b0;
    endcase

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic rst_lvl(input logic asserted);
    return pol ? asserted : ~asserted;
  endfunction

  task automatic issue(input logic [1:0] c);
    @(negedge clk); cmd_valid = 1; cmd = c;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic wait_done();
    waited = 0;
    while (!done && waited < 2000) begin @(negedge clk); waited++; end
    chk("R11 done seen", done, 1);
    @(negedge clk);
    chk("R11 done width", done, 0);
  endtask

  task automatic t_reset_state();
    chk("R1 state", state, 0);
    chk("R1 cpu_reset", cpu_reset, rst_lvl(1));
    chk("R1 busreq_n", busreq_n, 1);
    chk("R1 bus_oe", bus_oe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
  endtask

  task automatic t_restart(input int exp_state);
    int asserted_cnt = 0;
    logic oe0 = bus_oe, rq0 = busreq_n;
    bit moved = 0;
    issue(2'd3);
    while (!done) begin
      if (cpu_reset == rst_lvl(1)) asserted_cnt++;
      if (bus_oe != oe0 || busreq_n != rq0) moved = 1;
      @(negedge clk);
    end
    chk("R7 pulse length", asserted_cnt, RC);
    chk("R7 bus untouched", moved, 0);
    chk("R7 state", state, exp_state);
    chk("R8 reset released level", cpu_reset, rst_lvl(0));
    @(negedge clk);
    chk("R11 done width", done, 0);
  endtask

  task automatic t_request_grant(input int exp_state);
    bit early_oe = 0;
    ack_mode = 1;
    issue(2'd1);
    chk("R3 request driven", busreq_n, 0);
    while (!done) begin
      if (bus_oe) early_oe = 1;
      @(negedge clk);
    end
    chk("R3 no drivers before grant", early_oe, 0);
    chk("R3 state", state, exp_state);
    chk("R3 bus_oe", bus_oe, 1);
    chk("R3 tmo_err", tmo_err, 0);
    @(negedge clk);
  endtask

  task automatic t_noop(input logic [1:0] c, input int exp_state);
    issue(c);
    chk("R9 immediate done", done, 1);
    chk("R9 state kept", state, exp_state);
    chk("R2 oe follows owned", bus_oe, exp_state % 2);
    @(negedge clk);
  endtask

  task automatic t_release(input int mode, input int exp_state, input int exp_err);
    int t = 0, t_oe = -1, t_rq = -1;
    ack_mode = mode;
    issue(2'd2);
    while (!done && t < 2000) begin
      if (t_oe < 0 && !bus_oe) t_oe = t;
      if (t_rq < 0 && busreq_n) t_rq = t;
      @(negedge clk); t++;
    end
    chk("R5 drivers drop first", (t_oe >= 0 && t_rq > t_oe) ? 1 : 0, 1);
    chk("R5 state", state, exp_state);
    chk("R5 tmo_err", tmo_err, exp_err);
    chk("R5 busreq_n", busreq_n, 1);
    @(negedge clk);
    ack_mode = 1;
  endtask

  task automatic t_request_timeout_and_busy(input int exp_state);
    int n = 0;
    ack_mode = 0;
    issue(2'd1);
    repeat (3) @(negedge clk);
    cmd_valid = 1; cmd = 2'd0;
    @(negedge clk); cmd_valid = 0;
    n = 5;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk("R4 timeout window", (n >= TMO*DIV && n <= TMO*DIV + 4) ? 1 : 0, 1);
    chk("R4 tmo_err", tmo_err, 1);
    chk("R4 state kept", state, exp_state);
    chk("R4 busreq_n", busreq_n, 1);
    chk("R4 bus_oe", bus_oe, 0);
    @(negedge clk);
    chk("R10 busy command ignored", state, exp_state);
    chk("R10 cpu not reset", cpu_reset, rst_lvl(0));
    ack_mode = 1;
  endtask

  task automatic t_reset_cmd();
    issue(2'd0);
    chk("R6 reset asserted at once", cpu_reset, rst_lvl(1));
    wait_done();
    chk("R6 state", state, 0);
    chk("R6 bus_oe", bus_oe, 0);
    chk("R6 busreq_n", busreq_n, 1);
    chk("R6 cpu_reset", cpu_reset, rst_lvl(1));
  endtask

  task automatic t_polarity();
    pol = 0;
    @(negedge clk);
    chk("R8 active-low asserted", cpu_reset, 0);
    t_restart(2);
    chk("R8 active-low released", cpu_reset, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_request_grant(1);
    t_release(2, 0, 1);
    t_restart(2);
    t_request_grant(3);
    t_noop(2'd1, 3);
    t_restart(3);
    t_release(1, 2, 0);
    t_noop(2'd2, 2);
    t_request_timeout_and_busy(2);
    t_request_grant(3);
    t_reset_cmd();
    t_polarity();
    if (!timed_out) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    timed_out = 1;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule